// File: doc/BRIEF.md
# MFM Sector-Write Escape Decoder

This block sits between the source of a sector-write byte stream and an MFM write serializer. Most bytes pass straight through as ordinary data. A reserved escape byte (0x99 by default) is never sent on by itself. Instead, it makes the byte that follows it a command. That command can do one of several things:

- produce a sync byte whose clock bit is suppressed;
- produce an address, data or index mark byte;
- ask the serializer to insert the two CRC bytes;
- open a transparent window of a fixed length in which the escape value is ordinary data;
- end the write.

Both sides use valid/ready handshakes. Each output byte carries a two-bit tag that tells the serializer how to treat it. The block adds no storage on either side. A byte that produces output is accepted in the same cycle the serializer takes it. A byte that produces no output is taken at once, even when the output side is stalled. These are escape prefixes, window openers and terminators. After the write ends, the block swallows all further input until the next reset.

Top module: `mfm_wr_esc_decoder`

## Requirements
- R1: After a synchronous active-low reset, out_valid, stop_pulse and err_flag are low. Outside an escape, any byte other than 0x99 is output unchanged with out_kind 2'b00 (data).
- R2: A 0x99 received outside the raw window and outside an escape is accepted with no output, even while out_ready is low. The next byte is then read as a command.
- R3: The escape pairs 0x99 0xA1 and 0x99 0xC2 output 0xA1 or 0xC2 with out_kind 2'b01, a sync byte with a missing clock.
- R4: The escape pairs 0x99 0xFE, 0x99 0xFB and 0x99 0xFC output that byte with out_kind 2'b10 (mark).
- R5: The escape pair 0x99 0x99 outputs one literal 0x99 with out_kind 2'b00.
- R6: The escape pair 0x99 0x04 outputs one CRC request: out_kind 2'b11 with out_byte 0x00.
- R7: The escape pair 0x99 0x0F outputs nothing. The next 512 accepted bytes are output as data (2'b00), 0x99 included. The byte after the 512th is parsed normally again.
- R8: The escape pair 0x99 0x08 raises stop_pulse for exactly the cycle in which the command byte is accepted. From then until reset, every input byte is accepted (in_ready high) and has no effect: out_valid and stop_pulse stay low.
- R9: An escape followed by any byte not listed in R3 to R8 behaves as R8. In addition, err_flag goes high in the next cycle and stays high until reset.
- R10: An input byte that produces output is accepted only when out_ready is high. While it waits, out_valid, out_byte and out_kind hold steady for as long as the input is held.
- R11: A typical preamble passes in order and without loss under random stalls: gap bytes 0x4E, zero bytes, three escaped 0xA1 syncs and an escaped 0xFB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Input byte is taken this cycle |
| in_byte | input | 8 | Write stream byte |
| out_ready | input | 1 | Serializer takes the output byte |
| out_valid | output | 1 | Output byte is present |
| out_byte | output | 8 | Byte for the serializer |
| out_kind | output | 2 | 00 data, 01 sync with missing clock, 10 mark, 11 CRC request |
| stop_pulse | output | 1 | One-cycle end-of-write strobe |
| err_flag | output | 1 | Sticky: an undefined command was seen |

## Verification
Two functions can fall in the same cycle. The raw window can close on a 0x99 data byte, and the very next byte can be a real escape. This is provoked by ending a 512-byte window with 0x99 and following it at once with 0x99 0xA1. The check requires the last byte to come out as data and the following pair as a sync byte. The same boundary also meets output back-pressure, because out_ready is randomly withheld on the final window byte. The window must not close until that byte is actually taken. A behavioural model of the stream, kept in the bench, judges every cycle.

// File: rtl/mfm_esc_pkg.sv
// Shared types for the MFM write-stream escape decoder.
// Assumes an 8-bit stream; the encodings below are visible at the ports.
package mfm_esc_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_SYNC = 2'b01,
        KIND_MARK = 2'b10,
        KIND_CRC  = 2'b11
    } byte_kind_t;

    typedef enum logic [1:0] {
        ST_PLAIN,
        ST_CMD,
        ST_RAW,
        ST_HALT
    } parse_st_t;

    typedef enum logic [1:0] {
        ACT_EMIT,
        ACT_RAW,
        ACT_STOP,
        ACT_BAD
    } cmd_act_t;

    typedef struct packed {
        cmd_act_t   act;
        byte_kind_t kind;
        logic [7:0] emit;
    } cmd_dec_t;

    localparam logic [7:0] CMD_SYNC_A = 8'hA1;
    localparam logic [7:0] CMD_SYNC_B = 8'hC2;
    localparam logic [7:0] CMD_ID_AM  = 8'hFE;
    localparam logic [7:0] CMD_DAT_AM = 8'hFB;
    localparam logic [7:0] CMD_IDX_AM = 8'hFC;
    localparam logic [7:0] CMD_CRC    = 8'h04;
    localparam logic [7:0] CMD_STOP   = 8'h08;
    localparam logic [7:0] CMD_RAW    = 8'h0F;

endpackage

// File: rtl/esc_cmd_decode.sv
// Decodes the byte after an escape into an action, an output tag and the
// byte to emit. Purely combinational; assumes it is looked at only in the
// command state of the parser.
module esc_cmd_decode
    import mfm_esc_pkg::*;
#(
    parameter logic [7:0] ESC_CODE = 8'h99
) (
    input  logic [7:0] cmd,
    output cmd_dec_t   dec
);

    // Map the command byte to its action
    always_comb begin
        dec.act  = ACT_BAD;
        dec.kind = KIND_DATA;
        dec.emit = cmd;
        if (cmd == ESC_CODE) begin
            dec.act = ACT_EMIT;
        end else begin
            case (cmd)
                CMD_SYNC_A, CMD_SYNC_B: begin
                    dec.act  = ACT_EMIT;
                    dec.kind = KIND_SYNC;
                end
                CMD_ID_AM, CMD_DAT_AM, CMD_IDX_AM: begin
                    dec.act  = ACT_EMIT;
                    dec.kind = KIND_MARK;
                end
                CMD_CRC: begin
                    dec.act  = ACT_EMIT;
                    dec.kind = KIND_CRC;
                    dec.emit = 8'h00;
                end
                CMD_RAW:  dec.act = ACT_RAW;
                CMD_STOP: dec.act = ACT_STOP;
                default:  dec.act = ACT_BAD;
            endcase
        end
    end

endmodule

// File: rtl/raw_window_ctr.sv
// Counts the bytes taken inside a transparent window and flags the last one.
// Assumes open and step are never high together.
module raw_window_ctr #(
    parameter int RAW_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open,
    input  logic step,
    output logic last
);

    localparam int CW = $clog2(RAW_LEN + 1);

    logic [CW-1:0] cnt;

    // Flag the byte that brings the count to the window length
    assign last = (cnt == CW'(RAW_LEN - 1));

    // Restart on open, advance per accepted byte, wrap at the end
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (open)   cnt <= '0;
        else if (step)   cnt <= last ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/mfm_wr_esc_decoder.sv
// Turns a sector-write byte stream into tagged bytes for an MFM serializer.
// Input and output are valid/ready. Bytes that produce output pass through
// without buffering. Escape prefixes, window openers and terminators are
// consumed at once. Assumes the stream source holds in_byte while
// in_valid is high and in_ready is low.
module mfm_wr_esc_decoder
    import mfm_esc_pkg::*;
#(
    parameter logic [7:0] ESC_CODE = 8'h99,
    parameter int         RAW_LEN  = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic [1:0] out_kind,
    output logic       stop_pulse,
    output logic       err_flag
);

    parse_st_t state, state_nxt;
    cmd_dec_t  dec;
    logic      win_open, win_step, win_last, set_err;

    esc_cmd_decode #(.ESC_CODE(ESC_CODE)) u_dec (
        .cmd (in_byte),
        .dec (dec)
    );

    raw_window_ctr #(.RAW_LEN(RAW_LEN)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .open  (win_open),
        .step  (win_step),
        .last  (win_last)
    );

    // Decide outputs, handshake and next parser state for this byte
    always_comb begin
        state_nxt  = state;
        in_ready   = out_ready;
        out_valid  = 1'b0;
        out_byte   = in_byte;
        out_kind   = KIND_DATA;
        stop_pulse = 1'b0;
        win_open   = 1'b0;
        win_step   = 1'b0;
        set_err    = 1'b0;
        case (state)
            ST_PLAIN: begin
                if (in_byte == ESC_CODE) begin
                    in_ready = 1'b1;
                    if (in_valid) state_nxt = ST_CMD;
                end else begin
                    out_valid = in_valid;
                end
            end
            ST_CMD: begin
                case (dec.act)
                    ACT_EMIT: begin
                        out_valid = in_valid;
                        out_byte  = dec.emit;
                        out_kind  = dec.kind;
                        if (in_valid && out_ready) state_nxt = ST_PLAIN;
                    end
                    ACT_RAW: begin
                        in_ready = 1'b1;
                        win_open = in_valid;
                        if (in_valid) state_nxt = ST_RAW;
                    end
                    default: begin
                        in_ready   = 1'b1;
                        stop_pulse = in_valid;
                        set_err    = in_valid && (dec.act == ACT_BAD);
                        if (in_valid) state_nxt = ST_HALT;
                    end
                endcase
            end
            ST_RAW: begin
                out_valid = in_valid;
                win_step  = in_valid && out_ready;
                if (win_step && win_last) state_nxt = ST_PLAIN;
            end
            default: begin
                in_ready = 1'b1;
            end
        endcase
    end

    // Parser state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PLAIN;
        else        state <= state_nxt;
    end

    // Sticky flag for an undefined command
    always_ff @(posedge clk) begin
        if (!rst_n)       err_flag <= 1'b0;
        else if (set_err) err_flag <= 1'b1;
    end

endmodule

// File: rtl/mfm_wr_esc_checker.sv
// Temporal checks on the escape decoder, attached by bind. Looks at the
// ports and at the parser state only.
module mfm_wr_esc_checker
    import mfm_esc_pkg::*;
#(
    parameter logic [7:0] ESC_CODE = 8'h99
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_byte,
    input logic       out_ready,
    input logic       out_valid,
    input logic [1:0] out_kind,
    input logic       stop_pulse,
    input logic       err_flag,
    input parse_st_t  state
);

    logic halted_seen;

    // Remember that a stop has been issued since reset
    always_ff @(posedge clk) begin
        if (!rst_n)          halted_seen <= 1'b0;
        else if (stop_pulse) halted_seen <= 1'b1;
    end

    assert_quiet_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_seen |-> (!out_valid && !stop_pulse));

    assert_stop_consumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (in_ready && in_valid));

    assert_err_follows_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(stop_pulse));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_raw_is_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAW && in_valid) |-> (out_valid && out_kind == KIND_DATA));

    assert_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_escape_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAIN && in_valid && in_byte == ESC_CODE) |-> (!out_valid && in_ready));

endmodule

bind mfm_wr_esc_decoder mfm_wr_esc_checker #(.ESC_CODE(ESC_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte    (in_byte),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_kind   (out_kind),
    .stop_pulse (stop_pulse),
    .err_flag   (err_flag),
    .state      (state)
);

// File: tb/test_mfm_wr_esc_decoder.sv
`timescale 1ns/1ps
// Bench: a behavioural stream model, compared with the design every cycle.
module test_mfm_wr_esc_decoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, out_ready, out_valid, stop_pulse, err_flag;
    logic [7:0] in_byte, out_byte;
    logic [1:0] out_kind;

    always #2 clk = ~clk;

    mfm_wr_esc_decoder i_mfm_wr_esc_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_ready(out_ready), .out_valid(out_valid),
        .out_byte(out_byte), .out_kind(out_kind), .stop_pulse(stop_pulse),
        .err_flag(err_flag)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    int  cycles = 0;
    logic [7:0] q[$];
    int  m_st;
    int  m_cnt;
    bit  m_err;

    // One comparison
    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reset both the design and the model, then check the idle outputs
    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b1;
        q.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_cnt = 0; m_err = 1'b0;
        #1;
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "stop_pulse after reset", stop_pulse, 0);
        chk("R1", "err_flag after reset", err_flag, 0);
    endtask

    // One clock of stimulus, model and comparison
    task automatic step(input bit want_v, input bit orr);
        logic [7:0] b;
        bit iv, e_rdy, e_ov, e_stop, n_err;
        logic [7:0] e_byte;
        logic [1:0] e_kind;
        int n_st, n_cnt;
        string tag;
        @(negedge clk);
        iv = want_v && (q.size() > 0);
        b  = (q.size() > 0) ? q[0] : 8'h00;
        in_valid = iv; in_byte = b; out_ready = orr;
        #1;
        e_rdy = orr; e_ov = 1'b0; e_byte = b; e_kind = 2'b00; e_stop = 1'b0;
        n_st = m_st; n_cnt = m_cnt; n_err = m_err; tag = "R1";
        case (m_st)
            0: begin
                if (b == 8'h99) begin
                    e_rdy = 1'b1; tag = "R2";
                    if (iv) n_st = 1;
                end else e_ov = iv;
            end
            1: begin
                if (b == 8'hA1 || b == 8'hC2)                   begin e_ov = iv; e_kind = 2'b01; tag = "R3"; end
                else if (b == 8'hFE || b == 8'hFB || b == 8'hFC) begin e_ov = iv; e_kind = 2'b10; tag = "R4"; end
                else if (b == 8'h99)                             begin e_ov = iv; tag = "R5"; end
                else if (b == 8'h04) begin e_ov = iv; e_kind = 2'b11; e_byte = 8'h00; tag = "R6"; end
                else if (b == 8'h0F) begin
                    e_rdy = 1'b1; tag = "R7";
                    if (iv) begin n_st = 2; n_cnt = 0; end
                end else begin
                    e_rdy = 1'b1; e_stop = iv;
                    tag = (b == 8'h08) ? "R8" : "R9";
                    if (iv) begin n_st = 3; if (b != 8'h08) n_err = 1'b1; end
                end
                if (e_ov && orr) n_st = 0;
            end
            2: begin
                e_ov = iv; tag = "R7";
                if (iv && orr) begin
                    n_cnt = m_cnt + 1;
                    if (n_cnt == 512) begin n_st = 0; n_cnt = 0; end
                end
            end
            default: begin
                e_rdy = 1'b1; tag = m_err ? "R9" : "R8";
            end
        endcase
        if (e_ov && !orr) tag = "R10";
        if (iv) chk(tag, "in_ready", in_ready, e_rdy);
        chk(tag, "out_valid", out_valid, e_ov);
        if (e_ov) begin
            chk(tag, "out_byte", out_byte, e_byte);
            chk(tag, "out_kind", out_kind, e_kind);
        end
        chk(tag, "stop_pulse", stop_pulse, e_stop);
        chk("R9", "err_flag", err_flag, m_err);
        @(posedge clk);
        if (iv && e_rdy) void'(q.pop_front());
        m_st = n_st; m_cnt = n_cnt; m_err = n_err;
        cycles++;
    endtask

    // Drain the queue with random stalls, then idle a few cycles
    task automatic drain(input int stall_pct);
        while (q.size() > 0 && cycles < 150000)
            step(($urandom % 100) >= 15, ($urandom % 100) >= stall_pct);
        if (q.size() > 0) begin
            n_vec++; n_bad++;
            $display("FAIL R1 watchdog: actual %0d bytes left expected 0", q.size());
        end
        repeat (4) step(1'b0, 1'b1);
    endtask

    task automatic esc(input logic [7:0] c);
        q.push_back(8'h99); q.push_back(c);
    endtask

    initial begin
        do_reset();
        // R11: preamble of gap, zeros, sync marks, data mark
        for (int i = 0; i < 10; i++) q.push_back(8'h4E);
        for (int i = 0; i < 12; i++) q.push_back(8'h00);
        for (int i = 0; i < 3; i++) esc(8'hA1);
        esc(8'hFB);
        drain(0);
        // R3..R6 and R10 with heavy back-pressure
        q.push_back(8'h12); esc(8'hC2); esc(8'hFE); esc(8'hFC);
        esc(8'h99); q.push_back(8'h5A); esc(8'h04); esc(8'hA1);
        drain(40);
        // R7: raw window ending on 0x99, then a real escape
        esc(8'h0F);
        for (int i = 0; i < 512; i++)
            q.push_back((i % 7 == 3 || i == 511) ? 8'h99 : 8'(i));
        esc(8'hA1); q.push_back(8'h33);
        // R8: stop, then bytes that must be ignored
        esc(8'h08);
        q.push_back(8'h44); esc(8'h55); esc(8'h08); q.push_back(8'h66);
        drain(30);
        // R9: undefined command
        do_reset();
        q.push_back(8'h34); esc(8'h55); q.push_back(8'h77); esc(8'h04);
        drain(20);
        chk("R9", "err_flag held", err_flag, 1);
        do_reset();
        chk("R9", "err_flag cleared by reset", err_flag, 0);
        q.push_back(8'hAB);
        drain(0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule